// File: doc/BRIEF.md
# Dual Reload Down-Counter with Cascade

This block has two down counters of equal width, called low and high. Each counter has a starting value that can be written and a current value that can be read. A counter that is enabled moves down by one on every clock. When it reaches zero, it loads its starting value again, so a starting value S gives a period of S+1 clocks. When a counter is stopped, writing its starting value also places that value in the current count. This lets software preset the counter before starting it.

A join input chains the two counters into one down counter of twice the width. The low half sits in the lower bits. The high half moves only when the low half wraps, and the pair reloads only when both halves are zero. Each counter's terminal event reaches an output in one of two forms, selected per output: a one-clock pulse, or a square wave that flips at every event. The same event can also raise a one-clock request on a chosen bit of an interrupt request vector.

Top module: `dual_reload_counter`

## Requirements
- R1: After reset, both current values are zero. Both wave outputs are low, and the whole interrupt vector is zero.
- R2: A starting-value write takes effect at the next clock. If the counter is stopped, the write also loads the current value. If the counter is running, the current value keeps counting, and the new starting value is used at the next reload.
- R3: A running counter whose current value is non-zero decreases by one per clock. A running counter at zero reloads its starting value at that clock, so a starting value S repeats every S+1 clocks.
- R4: While a counter is stopped and no load occurs, its current value stays unchanged. In joined mode the pair counts only while the low enable is set, and the high enable has no effect.
- R5: With join set, the pair acts as one down counter of width 2*CNT_W whose value is high*2^CNT_W + low. It starts from the concatenated starting values and decrements once per enabled clock. It wraps the low half to all ones when only the low half is zero, and it reloads both halves only when both are zero.
- R6: With form bit 0 (pulse), a wave output is high for exactly the one clock after a clock at which its terminal event occurred, and low otherwise.
- R7: With form bit 1 (square), a wave output flips after each terminal event. form_i[0] selects the low output and form_i[1] selects the high output. The form bit only chooses what is shown; the pulse and toggle state is kept in both forms.
- R8: In joined mode, the high output carries the terminal event of the joined counter. The low counter raises no event: its pulse stays low and its square wave holds.
- R9: A channel whose interrupt enable is set raises irq_o[pos], where pos is that channel's position input. The bit is high in the same clock as that channel's pulse. A disabled channel contributes nothing, and two channels that name the same position are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_lo_i | input | 1 | Low counter enable (enable of the pair when joined) |
| run_hi_i | input | 1 | High counter enable (ignored when joined) |
| join_i | input | 1 | Chain the two counters into one double-width counter |
| wr_lo_i | input | 1 | Write the low starting value |
| wr_hi_i | input | 1 | Write the high starting value |
| wdata_i | input | CNT_W | Starting value to write |
| form_i | input | 2 | Output form per channel: 0 pulse, 1 square (bit 0 low, bit 1 high) |
| lo_irq_en_i | input | 1 | Send low events to the interrupt vector |
| hi_irq_en_i | input | 1 | Send high (or joined) events to the interrupt vector |
| lo_irq_pos_i | input | $clog2(NUM_POS) | Interrupt position for the low channel |
| hi_irq_pos_i | input | $clog2(NUM_POS) | Interrupt position for the high channel |
| lo_cur_o | output | CNT_W | Low current value |
| hi_cur_o | output | CNT_W | High current value |
| lo_out_o | output | 1 | Low wave output |
| hi_out_o | output | 1 | High wave output |
| irq_o | output | NUM_POS | One-clock interrupt requests |

## Verification
The bench builds the block with CNT_W=4 and NUM_POS=4. It sweeps every starting value from 0 to 15 on the low counter, with the complementary value on the high counter, and checks every clock over several periods. In joined mode the pair is only 8 bits wide, so periods of up to 256 clocks, including the all-ones case, can be followed clock by clock against a simple modulo formula. Four interrupt positions are few enough that routing to a shared position and the effect of the enables can be checked bit by bit.

// File: rtl/dual_reload_counter_pkg.sv
package dual_reload_counter_pkg;
  typedef enum logic {
    FORM_PULSE  = 1'b0,
    FORM_SQUARE = 1'b1
  } wave_form_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_LO  = 0;
  localparam int unsigned CH_HI  = 1;
endpackage

// File: rtl/tmr_stage.sv
module tmr_stage #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] start_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cur_q   <= '0;
    end else begin
      if (wr_i) start_q <= wdata_i;
      if (load_i)      cur_q <= wdata_i;
      else if (step_i) cur_q <= reload_i ? start_q : cur_q - 1'b1;
    end
  end

  assign cur_o  = cur_q;
  assign zero_o = (cur_q == '0);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import dual_reload_counter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_i,
  input  wave_form_e form_i,
  output logic       out_o
);
  logic pulse_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      pulse_q <= ev_i;
      tog_q   <= tog_q ^ ev_i;
    end
  end

  // both forms keep their state; form only selects
  assign out_o = (form_i == FORM_SQUARE) ? tog_q : pulse_q;
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
  parameter int unsigned NUM_POS = 16,
  parameter int unsigned NUM_CH  = 2,
  localparam int unsigned PW     = $clog2(NUM_POS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    ev_i,
  input  logic [NUM_CH-1:0]    en_i,
  input  logic [NUM_CH*PW-1:0] pos_i,
  output logic [NUM_POS-1:0]   irq_o
);
  logic [NUM_POS-1:0] irq_d, irq_q;

  always_comb begin
    irq_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ev_i[c] && en_i[c]) irq_d[pos_i[c*PW +: PW]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dual_reload_counter.sv
module dual_reload_counter
  import dual_reload_counter_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_POS = 16,
  localparam int unsigned PW     = $clog2(NUM_POS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_lo_i,
  input  logic               run_hi_i,
  input  logic               join_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [1:0]         form_i,
  input  logic               lo_irq_en_i,
  input  logic               hi_irq_en_i,
  input  logic [PW-1:0]      lo_irq_pos_i,
  input  logic [PW-1:0]      hi_irq_pos_i,
  output logic [CNT_W-1:0]   lo_cur_o,
  output logic [CNT_W-1:0]   hi_cur_o,
  output logic               lo_out_o,
  output logic               hi_out_o,
  output logic [NUM_POS-1:0] irq_o
);
  logic [NUM_CH-1:0] wr, stopped, step, reload, zero, ev, wave;
  logic [CNT_W-1:0]  cur [NUM_CH];

  assign wr = {wr_hi_i, wr_lo_i};

  // low half always steps on its own enable; high follows low wrap when joined
  assign step[CH_LO]    = run_lo_i;
  assign step[CH_HI]    = join_i ? (run_lo_i & zero[CH_LO]) : run_hi_i;
  assign stopped[CH_LO] = ~run_lo_i;
  assign stopped[CH_HI] = join_i ? ~run_lo_i : ~run_hi_i;
  // joined: low wraps to all ones unless the whole pair is at zero
  assign reload[CH_LO]  = zero[CH_LO] & (~join_i | zero[CH_HI]);
  assign reload[CH_HI]  = zero[CH_HI];

  assign ev[CH_LO] = step[CH_LO] & zero[CH_LO] & ~join_i;
  assign ev[CH_HI] = step[CH_HI] & zero[CH_HI];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_stage #(.CNT_W(CNT_W)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr[c]),
      .wdata_i  (wdata_i),
      .load_i   (wr[c] & stopped[c]),
      .step_i   (step[c]),
      .reload_i (reload[c]),
      .cur_o    (cur[c]),
      .zero_o   (zero[c])
    );

    tmr_wave u_wave (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev[c]),
      .form_i (wave_form_e'(form_i[c])),
      .out_o  (wave[c])
    );
  end

  tmr_irq_route #(.NUM_POS(NUM_POS), .NUM_CH(NUM_CH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .en_i   ({hi_irq_en_i, lo_irq_en_i}),
    .pos_i  ({hi_irq_pos_i, lo_irq_pos_i}),
    .irq_o  (irq_o)
  );

  assign lo_cur_o = cur[CH_LO];
  assign hi_cur_o = cur[CH_HI];
  assign lo_out_o = wave[CH_LO];
  assign hi_out_o = wave[CH_HI];
endmodule

// File: rtl/dual_reload_counter_chk.sv
module dual_reload_counter_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_POS = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_lo_i,
  input logic               run_hi_i,
  input logic               join_i,
  input logic               wr_lo_i,
  input logic               wr_hi_i,
  input logic [CNT_W-1:0]   wdata_i,
  input logic [CNT_W-1:0]   lo_cur_o,
  input logic [CNT_W-1:0]   hi_cur_o,
  input logic [NUM_POS-1:0] irq_o
);
  AST_LOAD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i && !run_lo_i |=> lo_cur_o == $past(wdata_i)); // R2
  AST_DEC_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_lo_i && lo_cur_o != '0 |=> lo_cur_o == CNT_W'($past(lo_cur_o) - 1'b1)); // R3
  AST_HOLD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_lo_i && !wr_lo_i |=> $stable(lo_cur_o)); // R4
  AST_HOLD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !join_i && !run_hi_i && !wr_hi_i |=> $stable(hi_cur_o)); // R4
  AST_JOIN_HI_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_i && run_lo_i && lo_cur_o != '0 |=> $stable(hi_cur_o)); // R5
  AST_IRQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= 2); // R9
endmodule

bind dual_reload_counter dual_reload_counter_chk #(.CNT_W(CNT_W), .NUM_POS(NUM_POS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_lo_i (run_lo_i),
  .run_hi_i (run_hi_i),
  .join_i   (join_i),
  .wr_lo_i  (wr_lo_i),
  .wr_hi_i  (wr_hi_i),
  .wdata_i  (wdata_i),
  .lo_cur_o (lo_cur_o),
  .hi_cur_o (hi_cur_o),
  .irq_o    (irq_o)
);

// File: tb/dual_reload_counter_test.sv
module dual_reload_counter_test;
  localparam int unsigned W  = 4;
  localparam int unsigned NP = 4;
  localparam int unsigned PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_lo = 0, run_hi = 0, join_c = 0, wr_lo = 0, wr_hi = 0;
  logic [W-1:0]  wdata = '0;
  logic [1:0]    form = 2'b00;
  logic          lo_en = 0, hi_en = 0;
  logic [PW-1:0] lo_pos = '0, hi_pos = '0;
  logic [W-1:0]  lo_cur, hi_cur;
  logic          lo_out, hi_out;
  logic [NP-1:0] irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dual_reload_counter #(.CNT_W(W), .NUM_POS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_lo_i(run_lo), .run_hi_i(run_hi),
    .join_i(join_c), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .form_i(form), .lo_irq_en_i(lo_en), .hi_irq_en_i(hi_en),
    .lo_irq_pos_i(lo_pos), .hi_irq_pos_i(hi_pos), .lo_cur_o(lo_cur),
    .hi_cur_o(hi_cur), .lo_out_o(lo_out), .hi_out_o(hi_out), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // stopped write of both starting values
  task automatic preload(input int lo_v, input int hi_v);
    @(negedge clk); run_lo = 0; run_hi = 0; wr_lo = 1; wdata = W'(lo_v);
    @(negedge clk); wr_lo = 0; wr_hi = 1; wdata = W'(hi_v);
    @(negedge clk); wr_hi = 0;
    chk(lo_cur == W'(lo_v), "R2 lo preload", lo_cur, lo_v);
    chk(hi_cur == W'(hi_v), "R2 hi preload", hi_cur, hi_v);
  endtask

  task automatic read_sq(output logic l, output logic h);
    form = 2'b11; #1; l = lo_out; h = hi_out; form = 2'b00; #1;
  endtask

  task automatic sep_sweep(input int s);
    int sh, nmax;
    logic bl, bh, l, h;
    sh = 15 - s;
    preload(s, sh);
    read_sq(bl, bh);
    lo_pos = 2'd1; hi_pos = 2'd2; lo_en = 1; hi_en = 1;
    run_lo = 1; run_hi = 1;
    nmax = 3 * (s + 1) + 2;
    for (int n = 1; n <= nmax; n++) begin
      int el, eh;
      bit pl, ph;
      @(negedge clk); #1;
      el = s - (n % (s + 1));
      eh = sh - (n % (sh + 1));
      pl = (n % (s + 1)) == 0;
      ph = (n % (sh + 1)) == 0;
      chk(lo_cur == W'(el), "R3 lo count", lo_cur, el);
      chk(hi_cur == W'(eh), "R3 hi count", hi_cur, eh);
      chk(lo_out == pl, "R6 lo pulse", lo_out, pl);
      chk(hi_out == ph, "R6 hi pulse", hi_out, ph);
      chk(irq == {1'b0, ph, pl, 1'b0}, "R9 irq routing", irq, {ph, pl, 1'b0});
      read_sq(l, h);
      chk(l == (bl ^ ((n / (s + 1)) % 2 == 1)), "R7 lo square", l, bl ^ ((n / (s + 1)) % 2 == 1));
      chk(h == (bh ^ ((n / (sh + 1)) % 2 == 1)), "R7 hi square", h, bh ^ ((n / (sh + 1)) % 2 == 1));
    end
    run_lo = 0; run_hi = 0; lo_en = 0; hi_en = 0;
    @(negedge clk);
  endtask

  task automatic join_sweep(input int hs, input int ls);
    int s, nmax;
    logic bl, bh, l, h;
    join_c = 1;
    preload(ls, hs);
    read_sq(bl, bh);
    s = hs * 16 + ls;
    hi_en = 1; hi_pos = 2'd3; lo_en = 1; lo_pos = 2'd0;
    run_lo = 1; run_hi = 0;
    nmax = 2 * (s + 1) + 3;
    for (int n = 1; n <= nmax; n++) begin
      int v;
      bit p;
      @(negedge clk); #1;
      v = s - (n % (s + 1));
      p = (n % (s + 1)) == 0;
      chk(lo_cur == W'(v % 16), "R5 joined low half", lo_cur, v % 16);
      chk(hi_cur == W'(v / 16), "R5 joined high half", hi_cur, v / 16);
      chk(hi_out == p, "R8 joined pulse on high", hi_out, p);
      chk(lo_out == 1'b0, "R8 low pulse quiet", lo_out, 0);
      chk(irq == {p, 3'b000}, "R9 joined irq", irq, {p, 3'b000});
      read_sq(l, h);
      chk(l == bl, "R8 low square holds", l, bl);
      chk(h == (bh ^ ((n / (s + 1)) % 2 == 1)), "R7 joined square", h, bh ^ ((n / (s + 1)) % 2 == 1));
    end
    run_lo = 0; join_c = 0; lo_en = 0; hi_en = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lo_cur == 0 && hi_cur == 0, "R1 reset counts", {lo_cur, hi_cur}, 0);
    chk(lo_out == 0 && hi_out == 0, "R1 reset pulse outputs", {lo_out, hi_out}, 0);
    form = 2'b11; #1;
    chk(lo_out == 0 && hi_out == 0, "R1 reset square outputs", {lo_out, hi_out}, 0);
    form = 2'b00;
    chk(irq == 0, "R1 reset irq", irq, 0);
    rst_n = 1;

    for (int s = 0; s < 16; s++) sep_sweep(s);

    join_sweep(0, 0);
    join_sweep(0, 3);
    join_sweep(1, 0);
    join_sweep(2, 5);
    join_sweep(15, 15);

    // R4 hold when stopped
    preload(9, 0);
    run_lo = 1;
    repeat (3) @(negedge clk);
    run_lo = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(lo_cur == 4'd6, "R4 hold stopped", lo_cur, 6);
      chk(lo_out == 0, "R4 no pulse while stopped", lo_out, 0);
    end

    // R4 high enable ignored in joined mode
    join_c = 1;
    preload(0, 4);
    run_hi = 1;
    repeat (4) @(negedge clk);
    chk(hi_cur == 4'd4 && lo_cur == 0, "R4 joined ignores high enable", {hi_cur, lo_cur}, 64);
    run_hi = 0; join_c = 0;

    // R2 write while running
    preload(5, 0);
    run_lo = 1;
    @(negedge clk);
    wr_lo = 1; wdata = 4'd7;
    @(negedge clk);
    wr_lo = 0;
    chk(lo_cur == 4'd3, "R2 running write keeps count", lo_cur, 3);
    repeat (3) @(negedge clk);
    chk(lo_cur == 4'd0, "R2 reaches zero", lo_cur, 0);
    @(negedge clk);
    chk(lo_cur == 4'd7, "R2 new start used at reload", lo_cur, 7);
    run_lo = 0;

    // R9 shared position and disabled channel
    preload(0, 0);
    lo_pos = 2'd3; hi_pos = 2'd3; lo_en = 1; hi_en = 0;
    run_lo = 1; run_hi = 1;
    repeat (2) @(negedge clk);
    chk(irq == 4'b1000, "R9 disabled channel silent", irq, 8);
    hi_en = 1; lo_pos = 2'd0; hi_pos = 2'd0;
    repeat (2) @(negedge clk);
    chk(irq == 4'b0001, "R9 shared position ORed", irq, 1);
    lo_en = 0; hi_en = 0;
    repeat (2) @(negedge clk);
    chk(irq == 4'b0000, "R9 both disabled", irq, 0);
    run_lo = 0; run_hi = 0;

    summary();
  end
endmodule